// File: doc/BRIEF.md
# Unaligned Load Merge Unit

This unit sits between a load port and a 32-bit memory that is read only as whole words. Each word is built from four byte lanes. A requester asks for a byte, a halfword or a word at any byte address. The unit turns that request into one aligned word read, or two reads on consecutive word addresses when the requested bytes cross a word boundary. It then shifts and joins the returned lanes into a right-justified result, extending it with sign or zeros as the request asks.

A strict-mode input changes how misaligned requests are handled. In strict mode, any halfword or word request that is not on its natural boundary gets a fault response and no memory read takes place. Only one request is in flight at a time. The unit drops `req_ready` from acceptance until its response pulse has ended.

Top module: `unaligned_load_merge`

## Requirements
- R1: While reset is asserted and after it is released, `req_ready` is high and `rsp_done`, `rsp_fault` and `mem_rd` are low until a request is accepted.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. In the cycle after acceptance, `mem_rd` is high and `mem_addr` is the byte address with its two low bits dropped. For a request served by a single read, `rsp_done` is a one-cycle pulse that becomes visible two edges after the accepting edge.
- R3: Memory data is taken one cycle after the read is presented. Lanes are little-endian: the byte at offset k within a word is `mem_rdata[8k+7:8k]`. The byte at the request address ends up in `rsp_data[7:0]`.
- R4: For byte and halfword results, `req_signed`=1 copies the top loaded bit into all higher bits and `req_signed`=0 fills them with zeros. Word results are unaffected by `req_signed`.
- R5: A halfword at offset 3, or a word at offset 1, 2 or 3, makes two reads on consecutive cycles, to word W and then word W+1. Lower-addressed bytes come from word W. `rsp_done` becomes visible three edges after acceptance.
- R6: When the first word of a straddling access is the last word address, the second read wraps around to word address 0.
- R7: In permissive mode (`strict_mode`=0), a misaligned access that stays within one word, such as a halfword at offset 1, makes exactly one read.
- R8: With `strict_mode`=1, a halfword at an odd address or a word with either low address bit set is misaligned. Such a request gets a one-cycle `rsp_fault` pulse in the cycle right after acceptance, with `rsp_done` low, `rsp_data` zero and no memory read. Bytes are never misaligned.
- R9: `req_ready` stays low from acceptance through the response pulse cycle and is high again in the following cycle. A `req_valid` raised while busy is ignored and causes no memory read.
- R10: `req_size` encodes 00 as byte, 01 as halfword, and 10 or 11 as word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Unit idle, can take a request |
| req_addr | input | ADDR_W | Byte address of the load |
| req_size | input | 2 | Access size code |
| req_signed | input | 1 | Sign-extend narrow results |
| strict_mode | input | 1 | Fault on misaligned requests instead of splitting |
| mem_rd | output | 1 | Word read strobe |
| mem_addr | output | ADDR_W-2 | Word address of the read |
| mem_rdata | input | 32 | Read data, valid the cycle after the strobe |
| rsp_done | output | 1 | Result pulse |
| rsp_fault | output | 1 | Misalignment fault pulse |
| rsp_data | output | 32 | Right-justified load result |

## Verification
The bench aims at the three word offsets that straddle a boundary and at the halfword at offset 3. A unit that got the split test wrong would return bytes from the wrong word, or make one read where two are needed. The wrap from the last word to word 0 is tested directly, since a miscomputed second address would read a far word. Strict-mode faults are checked for the absence of any read and for the response timing. A request raised while the unit is busy must leave the read count and the result unchanged; a unit that got this wrong would accept a second request or issue a stray read.

// File: rtl/unaligned_load_merge.sv
module unaligned_load_merge #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_signed,
  input  logic              strict_mode,
  output logic              mem_rd,
  output logic [ADDR_W-3:0] mem_addr,
  input  logic [31:0]       mem_rdata,
  output logic              rsp_done,
  output logic              rsp_fault,
  output logic [31:0]       rsp_data
);
  localparam int WA_W = ADDR_W - 2;

  typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_FIRST, S_SECOND, S_RESP} state_t;

  state_t          state;
  logic [WA_W-1:0] wa_q;
  logic [1:0]      off_q, size_q;
  logic            sgn_q, split_q, fault_q;
  logic [31:0]     lo_q, data_q;

  logic        is_word, is_half, misaligned, straddles, accept;
  logic [63:0] pair;
  logic [31:0] shifted, merged;

  assign is_word    = req_size[1];
  assign is_half    = (req_size == 2'b01);
  assign misaligned = (is_half & req_addr[0]) | (is_word & |req_addr[1:0]);
  assign straddles  = (is_half & &req_addr[1:0]) | (is_word & |req_addr[1:0]);

  assign req_ready = (state == S_IDLE);
  assign accept    = req_valid & req_ready;

  assign mem_rd   = (state == S_ISSUE) | ((state == S_FIRST) & split_q);
  assign mem_addr = (state == S_FIRST) ? wa_q + 1'b1 : wa_q;

  assign pair    = (state == S_SECOND) ? {mem_rdata, lo_q} : {32'd0, mem_rdata};
  assign shifted = 32'(pair >> {off_q, 3'b000});

  always_comb begin
    if (size_q[1])
      merged = shifted;
    else if (size_q[0])
      merged = {{16{sgn_q & shifted[15]}}, shifted[15:0]};
    else
      merged = {{24{sgn_q & shifted[7]}}, shifted[7:0]};
  end

  assign rsp_done  = (state == S_RESP) & ~fault_q;
  assign rsp_fault = (state == S_RESP) & fault_q;
  assign rsp_data  = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      wa_q    <= '0;
      off_q   <= '0;
      size_q  <= '0;
      sgn_q   <= 1'b0;
      split_q <= 1'b0;
      fault_q <= 1'b0;
      lo_q    <= '0;
      data_q  <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          wa_q    <= req_addr[ADDR_W-1:2];
          off_q   <= req_addr[1:0];
          size_q  <= req_size;
          sgn_q   <= req_signed;
          split_q <= straddles;
          fault_q <= strict_mode & misaligned;
          if (strict_mode & misaligned) begin
            data_q <= '0;
            state  <= S_RESP;
          end else begin
            state <= S_ISSUE;
          end
        end
        S_ISSUE: state <= S_FIRST;
        S_FIRST: begin
          lo_q <= mem_rdata;
          if (split_q) begin
            state <= S_SECOND;
          end else begin
            data_q <= merged;
            state  <= S_RESP;
          end
        end
        S_SECOND: begin
          data_q <= merged;
          state  <= S_RESP;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ulm_checker.sv
module ulm_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_size,
  input logic              strict_mode,
  input logic              mem_rd,
  input logic [ADDR_W-3:0] mem_addr,
  input logic              rsp_done,
  input logic              rsp_fault
);
  logic take, bad_align;
  assign take      = req_valid & req_ready;
  assign bad_align = ((req_size == 2'b01) & req_addr[0]) | (req_size[1] & |req_addr[1:0]);

  // R2
  issue_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && !(strict_mode && bad_align) |=> mem_rd && mem_addr == $past(req_addr[ADDR_W-1:2]));

  // R8
  strict_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && strict_mode && bad_align |=> rsp_fault && !rsp_done && !mem_rd);

  // R6
  second_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && $past(mem_rd) |-> mem_addr == (ADDR_W-2)'($past(mem_addr) + 1'b1));

  // R5
  read_pair_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && $past(mem_rd) |=> !mem_rd);

  // R9
  ready_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done || rsp_fault) |-> !req_ready ##1 req_ready);

  // R9
  busy_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !req_ready);
endmodule

bind unaligned_load_merge ulm_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_size(req_size), .strict_mode(strict_mode),
  .mem_rd(mem_rd), .mem_addr(mem_addr), .rsp_done(rsp_done), .rsp_fault(rsp_fault)
);

// File: tb/tb_unaligned_load_merge.sv
module tb_unaligned_load_merge;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_signed = 1'b0;
  logic        strict_mode = 1'b0;
  logic        mem_rd;
  logic [13:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic        rsp_done, rsp_fault;
  logic [31:0] rsp_data;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  unaligned_load_merge #(.ADDR_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_signed(req_signed),
    .strict_mode(strict_mode), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .rsp_done(rsp_done), .rsp_fault(rsp_fault),
    .rsp_data(rsp_data)
  );

  function automatic logic [31:0] memf(input logic [13:0] wa);
    return ({18'd0, wa} * 32'h9E3779B9) + 32'h13579BDF;
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= memf(mem_addr);

  function automatic int nbytes(input logic [1:0] sz);
    return sz[1] ? 4 : (sz[0] ? 2 : 1);
  endfunction

  function automatic logic [31:0] expect_load(input logic [15:0] a, input logic [1:0] sz, input logic sg);
    logic [31:0] r = '0;
    int n = nbytes(sz);
    for (int i = 0; i < n; i++) begin
      logic [15:0] ba = a + 16'(i);
      logic [31:0] w = memf(ba[15:2]) >> (8 * ba[1:0]);
      r = r | ({24'd0, w[7:0]} << (8 * i));
    end
    if (sg && n == 1 && r[7])  r = r | 32'hFFFFFF00;
    if (sg && n == 2 && r[15]) r = r | 32'hFFFF0000;
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [15:0] a, input logic [1:0] sz, input logic sg, input logic st,
                     input bit junk, output logic [31:0] d, output bit dn, output bit fl,
                     output int reads, output int lat, output logic [13:0] wa0,
                     output logic [13:0] wa1, output int busy_rdy, output bit after_ok);
    d = '0; dn = 0; fl = 0; reads = 0; lat = 0; wa0 = '0; wa1 = '0; busy_rdy = 0;
    @(negedge clk);
    req_addr = a; req_size = sz; req_signed = sg; strict_mode = st; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (lat < 8) begin
      if (mem_rd) begin
        if (reads == 0) wa0 = mem_addr; else wa1 = mem_addr;
        reads++;
      end
      if (req_ready) busy_rdy++;
      if (rsp_done || rsp_fault) begin
        dn = rsp_done; fl = rsp_fault; d = rsp_data;
        break;
      end
      if (junk && lat == 0) begin
        req_valid = 1'b1; req_addr = ~a; req_size = 2'b10; strict_mode = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
      lat++;
      if (lat == 1) req_valid = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    after_ok = req_ready && !mem_rd && !rsp_done && !rsp_fault;
  endtask

  // {addr, size, signed, strict, expected reads, expected fault}
  localparam logic [22:0] VEC [0:15] = '{
    {16'h0010, 2'd2, 1'b0, 1'b0, 2'd1, 1'b0},
    {16'h0011, 2'd2, 1'b0, 1'b0, 2'd2, 1'b0},
    {16'h0012, 2'd2, 1'b0, 1'b0, 2'd2, 1'b0},
    {16'h0013, 2'd2, 1'b0, 1'b0, 2'd2, 1'b0},
    {16'h0005, 2'd1, 1'b0, 1'b0, 2'd1, 1'b0},
    {16'h0005, 2'd1, 1'b1, 1'b0, 2'd1, 1'b0},
    {16'h0007, 2'd1, 1'b1, 1'b0, 2'd2, 1'b0},
    {16'h0006, 2'd1, 1'b0, 1'b0, 2'd1, 1'b0},
    {16'h0023, 2'd0, 1'b1, 1'b0, 2'd1, 1'b0},
    {16'h0021, 2'd0, 1'b0, 1'b0, 2'd1, 1'b0},
    {16'h0021, 2'd2, 1'b0, 1'b1, 2'd0, 1'b1},
    {16'h0005, 2'd1, 1'b0, 1'b1, 2'd0, 1'b1},
    {16'h0023, 2'd0, 1'b1, 1'b1, 2'd1, 1'b0},
    {16'h0024, 2'd2, 1'b1, 1'b1, 2'd1, 1'b0},
    {16'h0046, 2'd1, 1'b1, 1'b1, 2'd1, 1'b0},
    {16'h0033, 2'd3, 1'b0, 1'b0, 2'd2, 1'b0}
  };

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    bit dn, fl, aok;
    int reads, lat, brdy;
    logic [13:0] wa0, wa1;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(req_ready && !rsp_done && !rsp_fault && !mem_rd, "R1 reset outputs",
        {28'd0, req_ready, rsp_done, rsp_fault, mem_rd}, 32'h8);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_done && !rsp_fault && !mem_rd, "R1 after release",
        {28'd0, req_ready, rsp_done, rsp_fault, mem_rd}, 32'h8);

    for (int i = 0; i < 16; i++) begin
      logic [15:0] a = VEC[i][22:7];
      logic [1:0]  sz = VEC[i][6:5];
      logic        sg = VEC[i][4];
      logic        st = VEC[i][3];
      int          er = int'(VEC[i][2:1]);
      logic        ef = VEC[i][0];
      int          el = ef ? 0 : (er == 2 ? 3 : 2);
      logic [31:0] ed = ef ? 32'd0 : expect_load(a, sz, sg);
      run(a, sz, sg, st, 1'b0, d, dn, fl, reads, lat, wa0, wa1, brdy, aok);
      chk(fl == ef && dn == !ef, "R8 fault/done flags", {30'd0, dn, fl}, {30'd0, !ef, ef});
      chk(d == ed, (sz == 2'd3) ? "R10 word code 11 data" : "R3 R4 data", d, ed);
      chk(reads == er, er == 2 ? "R5 read count" : "R7 R8 read count", reads, er);
      chk(lat == el, er == 2 ? "R5 latency" : "R2 latency", lat, el);
      if (er > 0) chk(wa0 == a[15:2], "R2 first word address", {18'd0, wa0}, {18'd0, a[15:2]});
      if (er == 2) chk(wa1 == a[15:2] + 14'd1, "R5 second word address", {18'd0, wa1}, {18'd0, a[15:2] + 14'd1});
      chk(brdy == 0 && aok, "R9 ready while busy / after", brdy, 0);
    end

    // R6 wrap from last word to word 0
    run(16'hFFFE, 2'd2, 1'b0, 1'b0, 1'b0, d, dn, fl, reads, lat, wa0, wa1, brdy, aok);
    chk(wa0 == 14'h3FFF && wa1 == 14'h0000 && reads == 2, "R6 wrap addresses",
        {wa0, wa1, 4'(reads)}, {14'h3FFF, 14'h0000, 4'd2});
    chk(d == expect_load(16'hFFFE, 2'd2, 1'b0), "R6 wrap data", d, expect_load(16'hFFFE, 2'd2, 1'b0));

    // R9 request raised while busy is ignored
    run(16'h0014, 2'd2, 1'b0, 1'b0, 1'b1, d, dn, fl, reads, lat, wa0, wa1, brdy, aok);
    chk(reads == 1 && lat == 2 && dn, "R9 busy request ignored", reads, 1);
    chk(d == expect_load(16'h0014, 2'd2, 1'b0), "R9 data unchanged", d, expect_load(16'h0014, 2'd2, 1'b0));
    chk(aok, "R9 no stray read after", {31'd0, aok}, 32'd1);

    // R4 sign versus zero extension on the same byte
    run(16'h0023, 2'd0, 1'b0, 1'b0, 1'b0, d, dn, fl, reads, lat, wa0, wa1, brdy, aok);
    chk(d[31:8] == 24'd0 && d == expect_load(16'h0023, 2'd0, 1'b0), "R4 zero extend", d, expect_load(16'h0023, 2'd0, 1'b0));

    // R7 permissive halfword at offset 1
    run(16'h0041, 2'd1, 1'b1, 1'b0, 1'b0, d, dn, fl, reads, lat, wa0, wa1, brdy, aok);
    chk(reads == 1 && d == expect_load(16'h0041, 2'd1, 1'b1), "R7 offset-1 halfword", d, expect_load(16'h0041, 2'd1, 1'b1));

    summary();
    $finish;
  end
endmodule